// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flagged Character Queue

This block turns an asynchronous serial line into a queue of received characters. It counts a 16x oversampling tick that arrives from an external rate generator. It qualifies each start bit at mid-bit, then samples the data, optional parity and stop positions at the centre of each bit. Every recovered character is stored with three quality flags: a stop-bit fault, a parity mismatch and a line break. These are kept in a 16-entry first-in first-out queue.

A host reads the oldest entry as one 11-bit word and removes it with a one-cycle read strobe. A 12-bit status vector shows that data is waiting and that a character was lost to overflow. An idle-timeout output tells the host that characters are waiting and the line has been quiet for a programmable number of character times. A loopback select feeds the receiver from the local transmitter's serial output instead of the external pin. Character width, parity and enables come in as direct configuration inputs. They are expected to stay stable while a character is being received.

Top module: `serial_rxq`

## Requirements
- R1: After reset the queue is empty, `stat_word` is all zero, `rd_word` is zero and `idle_to` is low.
- R2: With `sym_len` = 3 the receiver takes 8 data bits, least significant first. A clean frame yields a word with the character in bits 7:0 and bits 10:8 clear.
- R3: `sym_len` codes 0, 1 and 2 select 5, 6 and 7 data bits. The unused upper bits of the character field read as zero.
- R4: With `par_en` high, one parity bit follows the data. With `par_even` high, an even count of ones over data and parity is correct; with it low, an odd count is correct. A mismatch sets bit 9 of the word.
- R5: With `par_en` low, no parity bit is expected and bit 9 of the word is never set.
- R6: A stop position sampled low sets bit 8 (framing error). Bit 10 stays clear unless R7 applies.
- R7: If the line is low from the start bit through the stop position, one entry is stored with character 0 and bits 8 and 10 set (word 0x500). No further entry is stored until the line has returned high.
- R8: A low pulse that ends before the eighth oversampling tick of the start bit is dropped and stores nothing.
- R9: The queue holds 16 entries and returns them in arrival order. `stat_word` bit 11 is high while it holds data. A character that arrives while it is full is dropped and sets `stat_word` bit 7, which stays set.
- R10: A one-cycle `fifo_clr` pulse empties the queue, discards unread entries and clears the overflow bit.
- R11: With `loop_sel` high the receiver listens only to `tx_loop`, and `rx_pin` has no effect; with it low, only `rx_pin` is used.
- R12: While `rx_en` is low the line is ignored and no entry is stored.
- R13: `idle_to` rises once the queue holds data and the receiver has been idle for `idle_limit` character times of 160 ticks each. It falls within two clocks of the queue emptying. An `idle_limit` of 0 keeps it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One-cycle 16x oversampling strobe |
| rx_pin | input | 1 | External serial input, idle high |
| tx_loop | input | 1 | Local transmitter serial output for loopback |
| loop_sel | input | 1 | 1 selects `tx_loop` as the receive line |
| rx_en | input | 1 | Receive enable |
| sym_len | input | 2 | Data-bit count code, bits = 5 + code |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 even parity, 0 odd parity |
| fifo_clr | input | 1 | Synchronous queue flush and overflow clear |
| idle_limit | input | 5 | Idle-timeout length in character times, 0 disables |
| rd_en | input | 1 | Pop the oldest entry when the queue holds data |
| rd_word | output | 11 | Oldest entry: 10 break, 9 parity error, 8 framing error, 7:0 character |
| stat_word | output | 12 | Status: bit 11 not empty, bit 7 overflow, others zero |
| idle_to | output | 1 | Idle-timeout indication |

## Verification
An arithmetic sweep of 8-bit characters, plus each shorter width, checks bit ordering and the masking of unused bits. A missed bit slot or a reversed order shows up as a wrong value. Parity is tried in both senses with correct and deliberately wrong parity bits, so inverting the sense and dropping the check are told apart. Stop-low frames, an all-low break, short start glitches and a 17-character burst separate framing, break, glitch rejection and overflow handling. Loopback with a stuck-low pin, disabled reception and a timed idle window show which input path is sampled and when the timeout is raised.

// File: rtl/rxq_pkg.sv
// Shared types and constants for the flagged serial receive queue.
// Assumes 8-bit characters at most; entry layout is decoded by the host.
package rxq_pkg;

    localparam int CHAR_W  = 8;
    localparam int ENTRY_W = CHAR_W + 3;
    localparam int STAT_W  = 12;
    localparam int STAT_NEMPTY_BIT = 11;
    localparam int STAT_OVR_BIT    = 7;

    // Entry layout: break in the top bit, then parity error, framing error, character.
    typedef struct packed {
        logic              brk;
        logic              perr;
        logic              ferr;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_START  = 3'd1,
        S_DATA   = 3'd2,
        S_PAR    = 3'd3,
        S_STOP   = 3'd4,
        S_WAITHI = 3'd5
    } rx_state_e;

endpackage

// File: rtl/rxq_line_sync.sv
// Two-flop synchroniser for the selected serial line.
// Assumes the line idles high; reset value is therefore high.
module rxq_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_sync
);

    logic meta_q;
    logic sync_q;

    // Shift the asynchronous line through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= line_async;
            sync_q <= meta_q;
        end
    end

    assign line_sync = sync_q;

endmodule

// File: rtl/rxq_deframer.sv
// Character recovery from an oversampled serial line.
// Validates a start bit at mid-bit, samples data/parity/stop at bit centres,
// and emits one flagged entry per frame. Configuration must be stable per frame.
module rxq_deframer
    import rxq_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      line,
    input  logic      rx_en,
    input  logic [1:0] sym_len,
    input  logic      par_en,
    input  logic      par_even,
    output logic      busy,
    output logic      push,
    output rx_entry_t entry
);

    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID_LAST = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(OSR - 1);

    rx_state_e         state_q;
    logic [CW-1:0]     cnt_q;
    logic [2:0]        bidx_q;
    logic [CHAR_W-1:0] data_q;
    logic              par_q;
    logic              par_used_q;
    logic              seen_hi_q;
    logic              push_q;
    rx_entry_t         entry_q;
    logic [2:0]        last_idx;
    logic              par_bad;
    logic              is_brk;

    // Index of the final data bit for the selected width.
    assign last_idx = 3'd4 + {1'b0, sym_len};

    // Parity mismatch over received data and parity bit.
    assign par_bad = par_used_q && ((^data_q ^ par_q) != !par_even);

    // A break is a frame with no high sample and a low stop position.
    assign is_brk  = !seen_hi_q && !line;

    // Frame sequencing and entry construction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            cnt_q      <= '0;
            bidx_q     <= '0;
            data_q     <= '0;
            par_q      <= 1'b0;
            par_used_q <= 1'b0;
            seen_hi_q  <= 1'b0;
            push_q     <= 1'b0;
            entry_q    <= '0;
        end else begin
            push_q <= 1'b0;
            if (!rx_en) begin
                state_q <= S_IDLE;
                cnt_q   <= '0;
            end else if (tick) begin
                unique case (state_q)
                    S_IDLE: begin
                        if (!line) begin
                            state_q <= S_START;
                            cnt_q   <= CW'(1);
                        end
                    end
                    S_START: begin
                        if (line) begin
                            state_q <= S_IDLE;
                            cnt_q   <= '0;
                        end else if (cnt_q == MID_LAST) begin
                            state_q    <= S_DATA;
                            cnt_q      <= '0;
                            bidx_q     <= '0;
                            data_q     <= '0;
                            par_q      <= 1'b0;
                            par_used_q <= 1'b0;
                            seen_hi_q  <= 1'b0;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    S_DATA: begin
                        if (cnt_q == BIT_LAST) begin
                            cnt_q          <= '0;
                            data_q[bidx_q] <= line;
                            seen_hi_q      <= seen_hi_q | line;
                            if (bidx_q == last_idx) begin
                                state_q <= par_en ? S_PAR : S_STOP;
                            end else begin
                                bidx_q <= bidx_q + 3'd1;
                            end
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    S_PAR: begin
                        if (cnt_q == BIT_LAST) begin
                            cnt_q      <= '0;
                            par_q      <= line;
                            par_used_q <= 1'b1;
                            seen_hi_q  <= seen_hi_q | line;
                            state_q    <= S_STOP;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    S_STOP: begin
                        if (cnt_q == BIT_LAST) begin
                            cnt_q  <= '0;
                            push_q <= 1'b1;
                            if (is_brk) begin
                                entry_q <= '{brk: 1'b1, perr: 1'b0, ferr: 1'b1, data: '0};
                            end else begin
                                entry_q <= '{brk: 1'b0, perr: par_bad, ferr: !line, data: data_q};
                            end
                            state_q <= line ? S_IDLE : S_WAITHI;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    S_WAITHI: begin
                        if (line) begin
                            state_q <= S_IDLE;
                        end
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    assign busy  = (state_q != S_IDLE);
    assign push  = push_q;
    assign entry = entry_q;

    // R12: an entry is only ever produced while reception was enabled.
    a_r12_push_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        push_q |-> $past(rx_en));

    // R8: a start is only accepted on a low sample.
    a_r8_start_seen_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA && $past(state_q) == S_START) |-> $past(!line));

    // R7: after a break entry the receiver rests until the line is high.
    a_r7_break_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (push_q && entry_q.brk && rx_en) |-> (state_q == S_WAITHI || $past(line) || line));

endmodule

// File: rtl/rxq_fifo.sv
// Flagged-entry queue with first-word fall-through head, sticky overflow flag
// and synchronous flush. A push into a full queue is dropped unless a pop
// happens in the same cycle.
module rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nempty,
    output logic         ovr
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic [AW:0]   cnt_q;
    logic          ovr_q;
    logic          full;
    logic          pop_ok;
    logic          push_ok;

    assign full    = (cnt_q == FULL_CNT);
    assign pop_ok  = pop && (cnt_q != '0);
    assign push_ok = push && (!full || pop_ok);

    // Store accepted entries.
    always_ff @(posedge clk) begin
        if (push_ok && !clr) begin
            mem[wr_ptr_q] <= wdata;
        end
    end

    // Pointer, occupancy and overflow tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            ovr_q    <= 1'b0;
        end else begin
            if (push_ok) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + AW'(1);
            end
            if (pop_ok) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + AW'(1);
            end
            if (push_ok && !pop_ok) begin
                cnt_q <= cnt_q + (AW+1)'(1);
            end else if (pop_ok && !push_ok) begin
                cnt_q <= cnt_q - (AW+1)'(1);
            end
            if (push && !push_ok) begin
                ovr_q <= 1'b1;
            end
        end
    end

    assign head   = mem[rd_ptr_q];
    assign nempty = (cnt_q != '0);
    assign ovr    = ovr_q;

    // R9: occupancy never exceeds the queue depth.
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    // R9: a push into a full queue without a pop marks overflow.
    a_r9_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (ovr_q && full));

    // R9: overflow stays set until a flush.
    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clr) |=> ovr_q);

    // R10: a flush leaves the queue empty with overflow cleared.
    a_r10_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !ovr_q));

endmodule

// File: rtl/rxq_idle_timer.sv
// Idle-timeout indicator: counts oversampling ticks while the queue holds data
// and the receiver is idle, in units of one character time.
// Counters restart whenever the queue is empty or a frame is in progress.
module rxq_idle_timer #(
    parameter int OSR       = 16,
    parameter int CHAR_BITS = 10,
    parameter int LW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          busy,
    input  logic          backlog,
    input  logic [LW-1:0] limit,
    output logic          flag
);

    localparam int TPC = OSR * CHAR_BITS;
    localparam int TW  = $clog2(TPC);
    localparam logic [TW-1:0] TPC_LAST = TW'(TPC - 1);
    localparam logic [LW-1:0] CH_MAX   = {LW{1'b1}};

    logic [TW-1:0] tick_cnt_q;
    logic [LW-1:0] char_cnt_q;

    // Accumulate idle ticks into whole character times, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || busy || !backlog) begin
            tick_cnt_q <= '0;
            char_cnt_q <= '0;
        end else if (tick) begin
            if (tick_cnt_q == TPC_LAST) begin
                tick_cnt_q <= '0;
                if (char_cnt_q != CH_MAX) begin
                    char_cnt_q <= char_cnt_q + LW'(1);
                end
            end else begin
                tick_cnt_q <= tick_cnt_q + TW'(1);
            end
        end
    end

    assign flag = (limit != '0) && (char_cnt_q >= limit);

    // R13: the timeout is only raised with data waiting in the queue.
    a_r13_needs_backlog: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> $past(backlog));

endmodule

// File: rtl/serial_rxq.sv
// Top level: line selection, synchronisation, character recovery, flagged
// queue and idle timeout. Configuration arrives as direct inputs.
module serial_rxq
    import rxq_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int DEPTH     = 16,
    parameter int CHAR_BITS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               os_tick,
    input  logic               rx_pin,
    input  logic               tx_loop,
    input  logic               loop_sel,
    input  logic               rx_en,
    input  logic [1:0]         sym_len,
    input  logic               par_en,
    input  logic               par_even,
    input  logic               fifo_clr,
    input  logic [4:0]         idle_limit,
    input  logic               rd_en,
    output logic [ENTRY_W-1:0] rd_word,
    output logic [STAT_W-1:0]  stat_word,
    output logic               idle_to
);

    logic               line_sel;
    logic               line_s;
    logic               busy;
    logic               push;
    rx_entry_t          entry;
    logic [ENTRY_W-1:0] head;
    logic               nempty;
    logic               ovr;

    assign line_sel = loop_sel ? tx_loop : rx_pin;

    rxq_line_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (line_sel),
        .line_sync  (line_s)
    );

    rxq_deframer #(.OSR(OSR)) u_deframer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .line     (line_s),
        .rx_en    (rx_en),
        .sym_len  (sym_len),
        .par_en   (par_en),
        .par_even (par_even),
        .busy     (busy),
        .push     (push),
        .entry    (entry)
    );

    rxq_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (fifo_clr),
        .push   (push),
        .wdata  (entry),
        .pop    (rd_en),
        .head   (head),
        .nempty (nempty),
        .ovr    (ovr)
    );

    rxq_idle_timer #(.OSR(OSR), .CHAR_BITS(CHAR_BITS), .LW(5)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .busy    (busy),
        .backlog (nempty),
        .limit   (idle_limit),
        .flag    (idle_to)
    );

    // Present the head entry only while the queue holds data.
    assign rd_word = nempty ? head : '0;

    // Assemble the status vector.
    always_comb begin
        stat_word                  = '0;
        stat_word[STAT_NEMPTY_BIT] = nempty;
        stat_word[STAT_OVR_BIT]    = ovr;
    end

    // R1: nothing is presented while the queue is empty.
    a_r1_empty_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_word[STAT_NEMPTY_BIT] |-> (rd_word == '0));

endmodule

// File: tb/serial_rxq_tb.sv
module serial_rxq_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        os_tick;
    logic        rx_pin;
    logic        tx_loop;
    logic        loop_sel;
    logic        rx_en;
    logic [1:0]  sym_len;
    logic        par_en;
    logic        par_even;
    logic        fifo_clr;
    logic [4:0]  idle_limit;
    logic        rd_en;
    logic [10:0] rd_word;
    logic [11:0] stat_word;
    logic        idle_to;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    localparam int BITCLK = 32;  // 16 ticks, one tick every two clocks

    always #2.5 clk = ~clk;

    serial_rxq u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_pin(rx_pin),
        .tx_loop(tx_loop), .loop_sel(loop_sel), .rx_en(rx_en),
        .sym_len(sym_len), .par_en(par_en), .par_even(par_even),
        .fifo_clr(fifo_clr), .idle_limit(idle_limit), .rd_en(rd_en),
        .rd_word(rd_word), .stat_word(stat_word), .idle_to(idle_to)
    );

    initial begin
        os_tick = 1'b0;
        forever begin
            @(negedge clk);
            os_tick = ~os_tick;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b, input bit to_loop);
        if (to_loop) tx_loop = b; else rx_pin = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit with_par,
                              input bit pv, input bit sv, input bit to_loop);
        put_bit(1'b0, to_loop);
        for (int i = 0; i < nb; i++) put_bit(d[i], to_loop);
        if (with_par) put_bit(pv, to_loop);
        put_bit(sv, to_loop);
        put_bit(1'b1, to_loop);
    endtask

    function automatic logic [10:0] expw(input logic [7:0] d, input int nb, input bit pe,
                                         input bit pev, input bit pv, input bit sv);
        logic [7:0] m;
        bit perr;
        m = d & 8'((1 << nb) - 1);
        if (m == 0 && (!pe || !pv) && !sv) return 11'h500;
        perr = pe && ((^m ^ pv) != !pev);
        return {1'b0, perr, !sv, m};
    endfunction

    task automatic pop_expect(input logic [10:0] exp, input string req);
        @(negedge clk);
        chk(stat_word[11] == 1'b1, req, stat_word, 12'h800);
        chk(rd_word == exp, req, rd_word, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_empty(input string req);
        @(negedge clk);
        chk(stat_word[11] == 1'b0, req, stat_word[11], 0);
    endtask

    initial begin
        rst_n = 1'b0; rx_pin = 1'b1; tx_loop = 1'b1; loop_sel = 1'b0;
        rx_en = 1'b1; sym_len = 2'd3; par_en = 1'b0; par_even = 1'b1;
        fifo_clr = 1'b0; idle_limit = 5'd5; rd_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(stat_word == 12'h000, "R1 stat", stat_word, 0);
        chk(rd_word == 11'h000, "R1 word", rd_word, 0);
        chk(idle_to == 1'b0, "R1 idle", idle_to, 0);

        // R2: 8-bit sweep, R5: parity off never flags bit 9
        for (int i = 0; i < 40; i++) begin
            logic [7:0] v;
            v = 8'((i * 53 + 7) & 255);
            if (i == 0) v = 8'h00;
            if (i == 1) v = 8'hFF;
            send_frame(v, 8, 0, 0, 1, 0);
            pop_expect(expw(v, 8, 0, 0, 0, 1), "R2 8-bit char");
        end
        par_even = 1'b0;
        send_frame(8'h37, 8, 0, 0, 1, 0);
        pop_expect({3'b000, 8'h37}, "R5 parity off");
        par_even = 1'b1;

        // R3: shorter widths
        for (int c = 0; c < 3; c++) begin
            sym_len = 2'(c);
            for (int i = 0; i < 8; i++) begin
                logic [7:0] v;
                v = 8'((i * 91 + c * 17 + 0) | 8'hE0);
                send_frame(v, 5 + c, 0, 0, 1, 0);
                pop_expect(expw(v, 5 + c, 0, 0, 0, 1), "R3 narrow char");
            end
        end
        sym_len = 2'd3;

        // R4: parity both senses, correct and wrong
        par_en = 1'b1;
        for (int ev = 0; ev < 2; ev++) begin
            par_even = ev[0];
            for (int i = 0; i < 6; i++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [7:0] v;
                    bit pv;
                    v = 8'(i * 45 + 3);
                    pv = (^v) ^ (ev == 0) ^ w[0];
                    send_frame(v, 8, 1, pv, 1, 0);
                    pop_expect(expw(v, 8, 1, ev[0], pv, 1), "R4 parity");
                end
            end
        end
        par_en = 1'b0; par_even = 1'b1;

        // R6: framing error
        send_frame(8'h5A, 8, 0, 0, 0, 0);
        pop_expect(11'h15A, "R6 framing");
        expect_empty("R6 single entry");

        // R7: break, exactly one entry
        rx_pin = 1'b0;
        repeat (15 * BITCLK) @(negedge clk);
        rx_pin = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        pop_expect(11'h500, "R7 break");
        expect_empty("R7 one entry");

        // R8: start glitch
        rx_pin = 1'b0;
        repeat (8) @(negedge clk);
        rx_pin = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        expect_empty("R8 glitch");
        send_frame(8'hC3, 8, 0, 0, 1, 0);
        pop_expect(11'h0C3, "R8 after glitch");

        // R9: overflow
        for (int i = 0; i < 17; i++) send_frame(8'(8'h30 + i), 8, 0, 0, 1, 0);
        @(negedge clk);
        chk(stat_word == 12'h880, "R9 full+ovr", stat_word, 12'h880);
        for (int i = 0; i < 16; i++) pop_expect({3'b000, 8'(8'h30 + i)}, "R9 order");
        @(negedge clk);
        chk(stat_word == 12'h080, "R9 ovr sticky", stat_word, 12'h080);

        // R10: flush
        for (int i = 0; i < 3; i++) send_frame(8'(8'h61 + i), 8, 0, 0, 1, 0);
        @(negedge clk); fifo_clr = 1'b1;
        @(negedge clk); fifo_clr = 1'b0;
        @(negedge clk);
        chk(stat_word == 12'h000, "R10 flush", stat_word, 0);
        send_frame(8'h99, 8, 0, 0, 1, 0);
        pop_expect(11'h099, "R10 after flush");

        // R11: loopback
        loop_sel = 1'b1; rx_pin = 1'b0;
        send_frame(8'hA5, 8, 0, 0, 1, 1);
        pop_expect(11'h0A5, "R11 loop path");
        rx_pin = 1'b1;
        send_frame(8'h3C, 8, 0, 0, 1, 0);
        expect_empty("R11 pin ignored");
        loop_sel = 1'b0;

        // R12: receive disable
        rx_en = 1'b0;
        send_frame(8'h81, 8, 0, 0, 1, 0);
        expect_empty("R12 disabled");
        rx_en = 1'b1;
        send_frame(8'h18, 8, 0, 0, 1, 0);
        pop_expect(11'h018, "R12 enabled");

        // R13: idle timeout of 2 character times = 320 ticks = 640 clocks
        idle_limit = 5'd2;
        begin
            int n;
            put_bit(1'b0, 0);
            for (int i = 0; i < 8; i++) put_bit(1'b1, 0);
            rx_pin = 1'b1;
            n = 0;
            while (!stat_word[11] && n < 200) begin @(negedge clk); n++; end
            n = 0;
            while (!idle_to && n < 2000) begin @(negedge clk); n++; end
            chk(n >= 630 && n <= 650, "R13 window", n, 640);
            pop_expect(11'h0FF, "R13 entry");
            repeat (2) @(negedge clk);
            chk(idle_to == 1'b0, "R13 falls", idle_to, 0);
        end
        idle_limit = 5'd0;
        send_frame(8'h11, 8, 0, 0, 1, 0);
        begin
            bit seen;
            seen = 0;
            repeat (1000) begin @(negedge clk); if (idle_to) seen = 1; end
            chk(!seen, "R13 limit zero", seen, 0);
        end
        pop_expect(11'h011, "R13 limit zero entry");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule